// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a synthesized high-speed clock runs at the frequency a reference clock asks for. The fast clock is divided down by a ratio picked from the reference rate, and a window of a fixed number of divided cycles is counted. Over the same window, a free-running counter in the reference domain counts reference edges. At each window end the reference count is sampled through a toggle handshake, and the difference from the previous sample is compared with the window length. The absolute difference is the frequency error in counts, where one count equals one part in the window length.

Two thresholds, each set in ppm, turn the error into an active-low loss-of-lock output. A large error declares loss. Only a much smaller error declares lock. An error between the two leaves the output as it was. The output starts low after reset and after any change of the rate select it ignores results until a clean window has been measured.

Top module: `freq_lock_detect`

## Requirements
- R1: `rate_sel` sets the divide ratio of the synthesized clock: 0 gives 4, 1 gives 16, 2 gives 32, 3 gives 64. A reference at the synthesized frequency divided by that ratio measures as zero error.
- R2: The error is the absolute difference between the reference edges counted over one window of 2^WIN_LOG2 divided cycles and 2^WIN_LOG2. `lock_n` is registered and changes only in the cycle after a measurement result arrives in the synthesized-clock domain.
- R3: The loss limit is LOSS_CNT = 2^WIN_LOG2 * LOSS_PPM / 10^6, truncated. A measured error above LOSS_CNT drives `lock_n` low. This holds for a reference that is too fast and for one that is too slow.
- R4: The lock limit is LOCK_CNT = 2^WIN_LOG2 * LOCK_PPM / 10^6, truncated. A measured error below LOCK_CNT drives `lock_n` high.
- R5: A measured error from LOCK_CNT to LOSS_CNT inclusive leaves `lock_n` unchanged, whether it was high or low.
- R6: `rst` (synchronous to `syn_clk`, active high) forces `lock_n` low. The first window result after reset only sets the baseline, so `lock_n` cannot rise before the second window end.
- R7: A change of `rate_sel` leaves `lock_n` unchanged and discards the next two window results, so no window that straddles the change is judged.
- R8: The reference snapshot crosses domains by a request/acknowledge toggle pair. The snapshot value changes only together with its acknowledge toggle, so the measurement is correct even at the slowest reference rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| syn_clk | input | 1 | Synthesized (fast) clock, clocks the divider, window and verdict |
| ref_clk | input | 1 | Reference clock being compared |
| rst | input | 1 | Synchronous active-high reset in the `syn_clk` domain |
| rate_sel | input | 2 | Reference rate select: divide ratio 4, 16, 32 or 64 |
| lock_n | output | 1 | Low = not locked, high = locked |

## Verification
The bench runs a scaled window of 128 divided cycles, with thresholds at 8 and 4 counts. It drives a behavioural reference offset by chosen ppm amounts. Offsets well beyond the loss limit, in both directions, separate a working loss test from one that ignores the sign of the error. A zero offset and a small offset confirm the lock test. An offset that lands midway between the limits is applied from both the locked and the unlocked state, and this is what tells real hysteresis apart from a single compare. Sweeping all four rate selections with a matching reference exposes any wrong divide ratio, and a check shortly after each rate change exposes a detector that judges the straddling window.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  localparam int RATE_W = 2;
  localparam int DIV_W  = 6;

  // Last count of the divider for a given rate select (ratio minus one).
  function automatic logic [DIV_W-1:0] div_last(input logic [RATE_W-1:0] r);
    int sh;
    sh = (r == '0) ? 2 : int'(r) + 3;
    return DIV_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/lockdet_window.sv
module lockdet_window
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              req_tgl,
  output logic              rate_chg
);
  logic [RATE_W-1:0]   rate_q;
  logic [DIV_W-1:0]    div_cnt;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                tick;

  assign tick = (div_cnt >= div_last(rate_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= rate_sel;
      rate_chg <= 1'b0;
      div_cnt  <= '0;
      win_cnt  <= '0;
      req_tgl  <= 1'b0;
    end else begin
      rate_q   <= rate_sel;
      rate_chg <= (rate_sel != rate_q);
      div_cnt  <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        win_cnt <= win_cnt + 1'b1;
        if (&win_cnt) req_tgl <= ~req_tgl;
      end
    end
  end
endmodule

// File: rtl/lockdet_ref_snap.sv
module lockdet_ref_snap #(
  parameter int CW = 17
) (
  input  logic          ref_clk,
  input  logic          rst,
  input  logic          req_tgl,
  output logic          ref_rst,
  output logic [CW-1:0] snap_val,
  output logic          ack_tgl
);
  logic [1:0]    rst_s;
  logic [2:0]    req_s;
  logic [CW-1:0] ref_cnt;

  always_ff @(posedge ref_clk) rst_s <= {rst_s[0], rst};
  assign ref_rst = rst_s[1];

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      req_s    <= '0;
      ref_cnt  <= '0;
      snap_val <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_s   <= {req_s[1:0], req_tgl};
      ref_cnt <= ref_cnt + 1'b1;
      if (req_s[2] ^ req_s[1]) begin
        snap_val <= ref_cnt;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/lockdet_judge.sv
module lockdet_judge #(
  parameter int WIN_LOG2 = 14,
  parameter int CW       = 17,
  parameter int LOSS_CNT = 8,
  parameter int LOCK_CNT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_chg,
  input  logic          ack_tgl,
  input  logic [CW-1:0] snap_val,
  output logic          lock_n
);
  localparam logic [CW-1:0] WIN_V  = CW'(2 ** WIN_LOG2);
  localparam logic [CW-1:0] LOSS_V = CW'(LOSS_CNT);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_CNT);

  logic [2:0]    ack_s;
  logic          ack_edge;
  logic [CW-1:0] base, delta, err;
  logic [1:0]    skip;

  assign ack_edge = ack_s[2] ^ ack_s[1];

  always_comb begin
    delta = snap_val - base;
    err   = (delta >= WIN_V) ? (delta - WIN_V) : (WIN_V - delta);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_s  <= '0;
      base   <= '0;
      skip   <= 2'd1;
      lock_n <= 1'b0;
    end else begin
      ack_s <= {ack_s[1:0], ack_tgl};
      if (rate_chg) begin
        skip <= 2'd2;
      end else if (ack_edge) begin
        base <= snap_val;
        if (skip != 2'd0)       skip   <= skip - 1'b1;
        else if (err > LOSS_V)  lock_n <= 1'b0;
        else if (err < LOCK_V)  lock_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
  import lockdet_pkg::*;
#(
  parameter int WIN_LOG2 = 14,
  parameter int LOSS_PPM = 500,
  parameter int LOCK_PPM = 250
) (
  input  logic              syn_clk,
  input  logic              ref_clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              lock_n
);
  localparam int CW       = WIN_LOG2 + 3;
  localparam int WIN      = 2 ** WIN_LOG2;
  localparam int LOSS_CNT = int'((longint'(WIN) * LOSS_PPM) / 1000000);
  localparam int LOCK_CNT = int'((longint'(WIN) * LOCK_PPM) / 1000000);

  logic          req_tgl;
  logic          rate_chg;
  logic          ref_rst;
  logic          ack_tgl;
  logic [CW-1:0] snap_val;

  lockdet_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .clk      (syn_clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .req_tgl  (req_tgl),
    .rate_chg (rate_chg)
  );

  lockdet_ref_snap #(.CW(CW)) u_snap (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .req_tgl  (req_tgl),
    .ref_rst  (ref_rst),
    .snap_val (snap_val),
    .ack_tgl  (ack_tgl)
  );

  lockdet_judge #(
    .WIN_LOG2 (WIN_LOG2),
    .CW       (CW),
    .LOSS_CNT (LOSS_CNT),
    .LOCK_CNT (LOCK_CNT)
  ) u_judge (
    .clk      (syn_clk),
    .rst      (rst),
    .rate_chg (rate_chg),
    .ack_tgl  (ack_tgl),
    .snap_val (snap_val),
    .lock_n   (lock_n)
  );
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
  parameter int CW = 17
) (
  input logic          syn_clk,
  input logic          ref_clk,
  input logic          rst,
  input logic          ref_rst,
  input logic          lock_n,
  input logic          rate_chg,
  input logic          ack_tgl,
  input logic [CW-1:0] snap_val
);
  logic [2:0] c_s;
  logic [3:0] since;

  always_ff @(posedge syn_clk) begin
    if (rst) begin
      c_s   <= '0;
      since <= 4'hf;
    end else begin
      c_s   <= {c_s[1:0], ack_tgl};
      since <= (c_s[2] ^ c_s[1]) ? 4'h0 : ((since == 4'hf) ? since : since + 1'b1);
    end
  end

  // R6
  reset_low_chk: assert property (@(posedge syn_clk) rst |=> !lock_n);

  // R2
  verdict_timing_chk: assert property (@(posedge syn_clk) disable iff (rst)
    !$stable(lock_n) |-> (since <= 4'd1));

  // R7
  rate_hold_chk: assert property (@(posedge syn_clk) disable iff (rst)
    rate_chg |=> $stable(lock_n));

  // R8
  snap_hold_chk: assert property (@(posedge ref_clk) disable iff (ref_rst !== 1'b0)
    !$stable(snap_val) |-> !$stable(ack_tgl));
endmodule

bind freq_lock_detect lockdet_chk #(.CW(CW)) u_chk (
  .syn_clk  (syn_clk),
  .ref_clk  (ref_clk),
  .rst      (rst),
  .ref_rst  (ref_rst),
  .lock_n   (lock_n),
  .rate_chg (rate_chg),
  .ack_tgl  (ack_tgl),
  .snap_val (snap_val)
);

// File: tb/freq_lock_detect_bench.sv
`timescale 1ns/1ps
module freq_lock_detect_bench;
  localparam int  WLOG   = 7;
  localparam int  WINB   = 2 ** WLOG;
  localparam int  LPPM   = 64000;
  localparam int  KPPM   = 32000;
  localparam real LOSS_C = real'((WINB * LPPM) / 1000000);
  localparam real LOCK_C = real'((WINB * KPPM) / 1000000);

  logic       syn_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       lock_n;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  real ref_half = 40.0;
  logic expv = 1'b0;

  freq_lock_detect #(.WIN_LOG2(WLOG), .LOSS_PPM(LPPM), .LOCK_PPM(KPPM))
    u_freq_lock_detect (
      .syn_clk (syn_clk), .ref_clk (ref_clk), .rst (rst),
      .rate_sel (rate_sel), .lock_n (lock_n));

  always #10 syn_clk = ~syn_clk;
  always begin
    #(ref_half);
    ref_clk = ~ref_clk;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge syn_clk);
  endtask

  task automatic set_ref(input int ratio, input int ppm);
    ref_half = 10.0 * ratio / (1.0 + ppm / 1.0e6);
  endtask

  function automatic logic predict(input logic prev, input int ppm);
    real e;
    e = WINB * ((ppm < 0) ? -ppm : ppm) / 1.0e6;
    if (e > LOSS_C) return 1'b0;
    if (e < LOCK_C) return 1'b1;
    return prev;
  endfunction

  task automatic check(input logic exp_v, input string req, input string what);
    checks++;
    if (lock_n !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, lock_n, exp_v);
    end
  endtask

  task automatic step(input int ratio, input int ppm, input string req, input string what);
    set_ref(ratio, ppm);
    wait_cyc(3 * ratio * WINB);
    expv = predict(expv, ppm);
    check(expv, req, what);
  endtask

  initial begin
    set_ref(4, 0);
    wait_cyc(20);
    rst = 1'b0;
    wait_cyc(2);
    check(1'b0, "R6", "low after reset");
    wait_cyc(4 * WINB + 100);
    check(1'b0, "R6", "first window is baseline only");
    wait_cyc(3 * 4 * WINB);
    expv = predict(1'b0, 0);
    check(expv, "R4", "lock at zero offset");

    step(4, 120000,  "R3", "fast reference declares loss");
    step(4, 47000,   "R5", "midway offset holds low");
    step(4, 0,       "R4", "relock at zero offset");
    step(4, 47000,   "R5", "midway offset holds high");
    step(4, -120000, "R3", "slow reference declares loss");
    step(4, 8000,    "R2", "small offset counts within lock window");

    for (int r = 1; r < 4; r++) begin
      int ratio;
      ratio = (r == 1) ? 16 : ((r == 2) ? 32 : 64);
      rate_sel = 2'(r);
      set_ref(ratio, 0);
      wait_cyc(ratio * WINB + 100);
      check(expv, "R7", "indicator held across rate change");
      wait_cyc(3 * ratio * WINB);
      expv = predict(expv, 0);
      check(expv, "R1", "matching reference locks at this rate");
      step(ratio, 120000, "R3", "loss at this rate");
      if (r < 3) step(ratio, 0, "R8", "handshake result relocks");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (185000) @(posedge syn_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule